// File: doc/BRIEF.md
# Inter-Packet Gap Timer with Carrier Blinder

This block paces a half-duplex Ethernet transmitter. It counts nibble-time ticks from the moment the medium goes quiet, either when carrier sense drops or when the port's own transmission ends. It raises a gap-satisfied flag once the programmed spacing has elapsed. When a transmit request is waiting at that point, it issues a one-cycle start pulse.

Gap lengths are held in 5-bit fields with one unit per nibble (4 bit-times). Three spacings are kept: one after ordinary data, one between jam bursts, and one from jam to data. A select input chooses which spacing applies. A separate blinder setting splits the gap into two zones. In the early zone, carrier activity throws the count back to zero. Once the count reaches the blinder point, carrier activity is disregarded until the gap completes, so a station that has waited most of the gap cannot be held off forever.

All settings are copied into shadow registers only while the port is disabled. Values below their legal minimum are raised to that minimum when they are copied. Changes made while the port runs have no effect.

Top module: `ipg_timer`

## Requirements
- R1: While reset is asserted and after it is released with the port disabled, gapDone and txStart are 0.
- R2: With the data spacing selected (gapSel 00 or 11) and no further activity, gapDone rises after exactly max(dataGapCfg, 3) ticks following the end of carrier or of txBusy. Each tick is one clock with tickEn high.
- R3: gapSel 01 selects the jam spacing and gapSel 10 selects the jam-to-data spacing. Each takes max(setting, 1) ticks.
- R4: Carrier sense seen while the count is below the blinder value clears the count to zero.
- R5: Carrier sense seen while the count is at or above the blinder value, but before the gap completes, does not disturb the count.
- R6: A blinder setting below 3 behaves as 3.
- R7: txStart is high exactly when gapDone and txRequest are high and txBusy is low. On the following cycle the count restarts and gapDone is low.
- R8: Settings are captured only while portEn is low. Changes made while portEn is high have no effect until the port is next disabled.
- R9: With portEn low, gapDone and txStart are low in the same cycle, and the count is cleared at the next edge.
- R10: Carrier sense seen after the gap has completed clears the count, so gapDone falls one cycle later.
- R11: While txBusy is high the count is held at zero. Counting begins when txBusy falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; low captures settings and clears the count |
| tickEn | input | 1 | One nibble time has elapsed |
| carrierSense | input | 1 | Carrier activity on the medium |
| txBusy | input | 1 | The port's own transmission is in progress |
| txRequest | input | 1 | A frame is waiting to be sent |
| gapSel | input | 2 | Spacing select: 00/11 data, 01 jam, 10 jam-to-data |
| dataGapCfg | input | 5 | Data spacing in nibbles (minimum 3) |
| jamGapCfg | input | 5 | Jam spacing in nibbles (minimum 1) |
| jamDataGapCfg | input | 5 | Jam-to-data spacing in nibbles (minimum 1) |
| blinderCfg | input | 5 | Blinder point in nibbles (minimum 3) |
| gapDone | output | 1 | Gap satisfied |
| txStart | output | 1 | One-cycle transmit start pulse |

## Verification
The count moves on a clock edge, so gapDone follows in the same cycle as the edge that brings the count to its limit. A carrier hit, the txBusy input or a start pulse brings gapDone down one edge later. txStart and the portEn gating of gapDone follow their inputs with no edge in between. Settings written while the port is disabled take effect after one edge. The bench drives inputs on the falling edge and compares both outputs one time unit later against a behavioural model that advances on each rising edge. Directed checks count whole cycles from the end of activity to the rise of gapDone, so every latency above is checked cycle by cycle.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

  typedef enum logic [1:0] {
    GAP_DATA     = 2'b00,
    GAP_JAM      = 2'b01,
    GAP_JAM_DATA = 2'b10,
    GAP_DATA_ALT = 2'b11
  } gap_sel_e;

  localparam int IDX_DATA     = 0;
  localparam int IDX_JAM      = 1;
  localparam int IDX_JAM_DATA = 2;
  localparam int IDX_BLIND    = 3;
  localparam int NUM_CFG      = 4;

  // control -> datapath
  typedef struct packed {
    logic capCfg;
    logic clrCnt;
    logic incCnt;
  } ipg_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic belowBlind;
    logic atGap;
  } ipg_status_t;

endpackage

// File: rtl/ipg_datapath.sv
module ipg_datapath
  import ipg_pkg::*;
#(
  parameter int CFG_W     = 5,
  parameter int DATA_MIN  = 3,
  parameter int JAM_MIN   = 1,
  parameter int BLIND_MIN = 3,
  parameter int DATA_RST  = 24,
  parameter int JAM_RST   = 8,
  parameter int BLIND_RST = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipg_strobe_t       strobe,
  input  logic [1:0]        gapSel,
  input  logic [CFG_W-1:0]  dataGapCfg,
  input  logic [CFG_W-1:0]  jamGapCfg,
  input  logic [CFG_W-1:0]  jamDataGapCfg,
  input  logic [CFG_W-1:0]  blinderCfg,
  output ipg_status_t       status,
  output logic [CFG_W-1:0]  cntQ,
  output logic [CFG_W-1:0]  blindQ
);

  localparam logic [CFG_W-1:0] CFG_MIN [NUM_CFG] = '{
    CFG_W'(DATA_MIN), CFG_W'(JAM_MIN), CFG_W'(JAM_MIN), CFG_W'(BLIND_MIN)};
  localparam logic [CFG_W-1:0] CFG_RST [NUM_CFG] = '{
    CFG_W'(DATA_RST), CFG_W'(JAM_RST), CFG_W'(JAM_RST), CFG_W'(BLIND_RST)};

  logic [CFG_W-1:0] cfgIn   [NUM_CFG];
  logic [CFG_W-1:0] shadowQ [NUM_CFG];
  logic [CFG_W-1:0] gapLim;

  assign cfgIn[IDX_DATA]     = dataGapCfg;
  assign cfgIn[IDX_JAM]      = jamGapCfg;
  assign cfgIn[IDX_JAM_DATA] = jamDataGapCfg;
  assign cfgIn[IDX_BLIND]    = blinderCfg;

  // one shadow register per setting, raised to its minimum on capture
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_shadow
    logic [CFG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= CFG_RST[g];
      end else if (strobe.capCfg) begin
        q <= (cfgIn[g] < CFG_MIN[g]) ? CFG_MIN[g] : cfgIn[g];
      end
    end
    assign shadowQ[g] = q;
  end

  always_comb begin
    case (gap_sel_e'(gapSel))
      GAP_JAM:      gapLim = shadowQ[IDX_JAM];
      GAP_JAM_DATA: gapLim = shadowQ[IDX_JAM_DATA];
      default:      gapLim = shadowQ[IDX_DATA];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.clrCnt) begin
      cntQ <= '0;
    end else if (strobe.incCnt) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign blindQ            = shadowQ[IDX_BLIND];
  assign status.belowBlind = cntQ < blindQ;
  assign status.atGap      = cntQ >= gapLim;

endmodule

// File: rtl/ipg_control.sv
module ipg_control
  import ipg_pkg::*;
(
  input  logic        portEn,
  input  logic        tickEn,
  input  logic        carrierSense,
  input  logic        txBusy,
  input  logic        txRequest,
  input  ipg_status_t status,
  output ipg_strobe_t strobe,
  output logic        gapDone,
  output logic        txStart
);

  logic carrierHit;
  logic doneInt;
  logic startInt;
  logic clrInt;

  always_comb begin
    doneInt    = portEn && status.atGap;
    startInt   = doneInt && txRequest && !txBusy;
    // carrier counts only in the early zone or once the gap is complete
    carrierHit = carrierSense && (status.belowBlind || status.atGap);
    clrInt     = !portEn || txBusy || startInt || carrierHit;

    strobe.capCfg = !portEn;
    strobe.clrCnt = clrInt;
    strobe.incCnt = tickEn && !status.atGap && !clrInt;
  end

  assign gapDone = doneInt;
  assign txStart = startInt;

endmodule

// File: rtl/ipg_timer.sv
module ipg_timer
  import ipg_pkg::*;
#(
  parameter int CFG_W     = 5,
  parameter int DATA_MIN  = 3,
  parameter int JAM_MIN   = 1,
  parameter int BLIND_MIN = 3,
  parameter int DATA_RST  = 24,
  parameter int JAM_RST   = 8,
  parameter int BLIND_RST = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             tickEn,
  input  logic             carrierSense,
  input  logic             txBusy,
  input  logic             txRequest,
  input  logic [1:0]       gapSel,
  input  logic [CFG_W-1:0] dataGapCfg,
  input  logic [CFG_W-1:0] jamGapCfg,
  input  logic [CFG_W-1:0] jamDataGapCfg,
  input  logic [CFG_W-1:0] blinderCfg,
  output logic             gapDone,
  output logic             txStart
);

  ipg_strobe_t      strobe;
  ipg_status_t      status;
  logic [CFG_W-1:0] cntQ;
  logic [CFG_W-1:0] blindQ;

  ipg_datapath #(
    .CFG_W(CFG_W), .DATA_MIN(DATA_MIN), .JAM_MIN(JAM_MIN),
    .BLIND_MIN(BLIND_MIN), .DATA_RST(DATA_RST), .JAM_RST(JAM_RST),
    .BLIND_RST(BLIND_RST)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .gapSel       (gapSel),
    .dataGapCfg   (dataGapCfg),
    .jamGapCfg    (jamGapCfg),
    .jamDataGapCfg(jamDataGapCfg),
    .blinderCfg   (blinderCfg),
    .status       (status),
    .cntQ         (cntQ),
    .blindQ       (blindQ)
  );

  ipg_control u_ctl (
    .portEn      (portEn),
    .tickEn      (tickEn),
    .carrierSense(carrierSense),
    .txBusy      (txBusy),
    .txRequest   (txRequest),
    .status      (status),
    .strobe      (strobe),
    .gapDone     (gapDone),
    .txStart     (txStart)
  );

endmodule

// File: rtl/ipg_timer_checker.sv
module ipg_timer_checker #(
  parameter int CFG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             portEn,
  input logic             tickEn,
  input logic             carrierSense,
  input logic             txBusy,
  input logic [1:0]       gapSel,
  input logic             gapDone,
  input logic             txStart,
  input logic [CFG_W-1:0] cntQ,
  input logic [CFG_W-1:0] blindQ
);

  localparam logic [CFG_W-1:0] ONE = {{(CFG_W-1){1'b0}}, 1'b1};

  // R7
  start_needs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> gapDone);

  // R7
  start_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !gapDone);

  // R9
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> cntQ == '0);

  // R11
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> !gapDone);

  // R4
  early_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    portEn && carrierSense && (cntQ < blindQ) |=> cntQ == '0);

  // R5
  late_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    portEn && carrierSense && tickEn && !txBusy && !gapDone && (cntQ >= blindQ)
    |=> cntQ == $past(cntQ) + ONE);

  // R10
  idle_carrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapDone && carrierSense |=> !gapDone);

  // R2
  rise_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gapDone) && $stable(gapSel) && $stable(portEn) |-> $past(tickEn));

endmodule

bind ipg_timer ipg_timer_checker #(.CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .portEn      (portEn),
  .tickEn      (tickEn),
  .carrierSense(carrierSense),
  .txBusy      (txBusy),
  .gapSel      (gapSel),
  .gapDone     (gapDone),
  .txStart     (txStart),
  .cntQ        (cntQ),
  .blindQ      (blindQ)
);

// File: tb/ipg_timer_bench.sv
module ipg_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b0;
  logic       tickEn = 1'b1;
  logic       crs = 1'b0;
  logic       busy = 1'b0;
  logic       req = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [4:0] dataCfg = 5'd24;
  logic [4:0] jamCfg = 5'd8;
  logic [4:0] jdCfg = 5'd8;
  logic [4:0] blindCfg = 5'd16;
  logic       gapDone;
  logic       txStart;

  int    nChecks = 0;
  int    nFail = 0;
  string curTag = "R1";

  // behavioural reference state
  int mData = 24, mJam = 8, mJd = 8, mBlind = 16, mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipg_timer u_ipg_timer (
    .clk(clk), .rstN(rstN), .portEn(portEn), .tickEn(tickEn),
    .carrierSense(crs), .txBusy(busy), .txRequest(req), .gapSel(sel),
    .dataGapCfg(dataCfg), .jamGapCfg(jamCfg), .jamDataGapCfg(jdCfg),
    .blinderCfg(blindCfg), .gapDone(gapDone), .txStart(txStart)
  );

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int limNow();
    if (sel == 2'b01) return mJam;
    if (sel == 2'b10) return mJd;
    return mData;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare outputs, then advance one clock together with the model
  task automatic step();
    int  l;
    bit  expDone, expStart;
    #1;
    l        = limNow();
    expDone  = portEn && (mCnt >= l);
    expStart = expDone && req && !busy;
    check(curTag, "gapDone", int'(gapDone), int'(expDone));
    check(curTag, "txStart", int'(txStart), int'(expStart));
    @(posedge clk);
    if (!rstN) begin
      mData = 24; mJam = 8; mJd = 8; mBlind = 16; mCnt = 0;
    end else begin
      if (!portEn || busy || expStart || (crs && (mCnt < mBlind || mCnt >= l)))
        mCnt = 0;
      else if (tickEn && mCnt < l)
        mCnt++;
      if (!portEn) begin
        mData  = atLeast(int'(dataCfg), 3);
        mJam   = atLeast(int'(jamCfg), 1);
        mJd    = atLeast(int'(jdCfg), 1);
        mBlind = atLeast(int'(blindCfg), 3);
      end
    end
    @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!gapDone && n < 100) begin
      step();
      n++;
    end
  endtask

  task automatic pulseAndMeasure(output int n);
    crs = 1'b1;
    step();
    crs = 1'b0;
    measure(n);
  endtask

  task automatic reprogram();
    portEn = 1'b0;
    step();
    portEn = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1", "gapDone after reset", int'(gapDone), 0);
    check("R1", "txStart after reset", int'(txStart), 0);

    // R2: data spacing, normal and clamped
    curTag = "R2";
    dataCfg = 5'd5; blindCfg = 5'd3;
    reprogram();
    pulseAndMeasure(n);
    check("R2", "ticks to gap (5)", n, 5);
    dataCfg = 5'd1;
    reprogram();
    pulseAndMeasure(n);
    check("R2", "ticks to gap (clamped 3)", n, 3);

    // R4: early carrier restarts the count
    curTag = "R4";
    dataCfg = 5'd10; blindCfg = 5'd6;
    reprogram();
    crs = 1'b1; step(); crs = 1'b0;
    repeat (4) step();
    crs = 1'b1; step(); crs = 1'b0;
    measure(n);
    check("R4", "ticks after early carrier", n, 10);

    // R5: carrier past the blinder point is ignored
    curTag = "R5";
    crs = 1'b1; step(); crs = 1'b0;
    repeat (7) step();
    crs = 1'b1; step(); crs = 1'b0;
    measure(n);
    check("R5", "remaining ticks after late carrier", n, 2);

    // R6: blinder of 1 acts as 3, so carrier at count 2 restarts
    curTag = "R6";
    blindCfg = 5'd1;
    reprogram();
    crs = 1'b1; step(); crs = 1'b0;
    repeat (2) step();
    crs = 1'b1; step(); crs = 1'b0;
    measure(n);
    check("R6", "ticks after carrier at count 2", n, 10);

    // R10: carrier after completion restarts
    curTag = "R10";
    crs = 1'b1; step(); crs = 1'b0;
    check("R10", "gapDone after idle carrier", int'(gapDone), 0);
    measure(n);
    check("R10", "ticks after idle carrier", n, 10);

    // R7: start pulse
    curTag = "R7";
    req = 1'b1;
    #1;
    check("R7", "txStart with gap and request", int'(txStart), 1);
    step();
    check("R7", "txStart one cycle later", int'(txStart), 0);
    check("R7", "gapDone one cycle later", int'(gapDone), 0);
    req = 1'b0;
    crs = 1'b1; step(); crs = 1'b0;
    req = 1'b1;
    repeat (3) step();
    check("R7", "txStart before gap", int'(txStart), 0);
    req = 1'b0;
    measure(n);
    check("R7", "remaining ticks", n, 7);

    // R11: own transmission holds the count
    curTag = "R11";
    busy = 1'b1; req = 1'b1;
    #1;
    check("R7", "txStart while busy", int'(txStart), 0);
    repeat (5) step();
    check("R11", "gapDone while busy", int'(gapDone), 0);
    busy = 1'b0; req = 1'b0;
    measure(n);
    check("R11", "ticks after busy falls", n, 10);

    // R8: change while enabled has no effect
    curTag = "R8";
    dataCfg = 5'd20;
    pulseAndMeasure(n);
    check("R8", "ticks ignore live change", n, 10);

    // R9: disable gates and clears
    curTag = "R9";
    portEn = 1'b0;
    #1;
    check("R9", "gapDone while disabled", int'(gapDone), 0);
    step();
    portEn = 1'b1;
    measure(n);
    check("R8", "ticks after capture", n, 20);

    // R3: jam and jam-to-data spacings
    curTag = "R3";
    sel = 2'b01; jamCfg = 5'd2; jdCfg = 5'd7;
    reprogram();
    measure(n);
    check("R3", "jam ticks", n, 2);
    jamCfg = 5'd0;
    reprogram();
    measure(n);
    check("R3", "jam ticks clamped", n, 1);
    sel = 2'b10;
    reprogram();
    measure(n);
    check("R3", "jam-to-data ticks", n, 7);
    sel = 2'b11; dataCfg = 5'd4;
    reprogram();
    measure(n);
    check("R2", "alternate data select ticks", n, 4);

    // mixed traffic against the model (R4 R5 R10 R11 paths)
    curTag = "R5";
    for (int i = 0; i < 4000; i++) begin
      tickEn = ($urandom_range(0, 3) != 0);
      crs    = ($urandom_range(0, 9) == 0);
      busy   = ($urandom_range(0, 24) == 0);
      req    = ($urandom_range(0, 2) == 0);
      sel    = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 149) == 0) begin
        portEn   = 1'b0;
        dataCfg  = 5'($urandom_range(0, 31));
        jamCfg   = 5'($urandom_range(0, 31));
        jdCfg    = 5'($urandom_range(0, 31));
        blindCfg = 5'($urandom_range(0, 31));
      end else begin
        portEn = 1'b1;
      end
      step();
    end

    summary();
    $finish;
  end

endmodule